// File: doc/BRIEF.md
# Row-Matching Hold-Grant Switch Allocator

This block is the switch allocator of one router in an on-chip network that carries memory requests toward DRAM controllers. Every cycle each input port shows a request vector with one bit per output port, and a DRAM row tag for the request it carries. The block returns a grant matrix that pairs inputs with outputs. An output is granted to at most one input, and an input receives at most one output. Normal allocation is separable and has two stages. A round-robin arbiter at each input picks one of the outputs that input wants. A round-robin arbiter at each output then picks one of the inputs that selected it.

A mode input can add a sticky override on top of this. In hold mode, a pair that won in the previous cycle wins again as long as the input still requests that output. In row-hold mode, the pair is repeated only while the input's row tag equals the row recorded with the earlier grant. Repeating pairs this way keeps a stream of same-row requests together as it crosses the router, so a simple in-order DRAM controller downstream sees longer row hits. A held pair takes both its input and its output out of normal arbitration for that cycle. Held grants do not move the round-robin pointers.

Top module: `rmhg_switch_alloc`

## Requirements
- R1: Every cycle, each output column of `gnt_o` has at most one bit set and each input row has at most one bit set. A grant bit is set only where the matching `req_i` bit is set. Bit `i*N_OUT+o` of both vectors stands for input i and output o.
- R2: With `mode_i` = 0 (plain), grants come only from two-stage round-robin arbitration. When all inputs keep requesting one output, it is granted to inputs 0, 1, 2, 3 in turn on successive cycles.
- R3: With `mode_i` = 1 (hold), a pair granted in the previous cycle, under the same mode, is granted again while the input still requests that output. This holds even if the input's row tag has changed.
- R4: With `mode_i` = 2 (row-hold), a pair granted in the previous cycle is granted again only if the input's current row tag equals the row it carried when that grant was made. A different row releases the pair to normal arbitration.
- R5: If a previously granted input no longer requests its output, the output is assigned by normal arbitration among the remaining requesters.
- R6: A held pair removes its input and its output from normal arbitration in that cycle. The other inputs and outputs are still arbitrated in the same cycle.
- R7: In the first cycle after `mode_i` changes value, no hold applies and all grants come from normal arbitration.
- R8: While `rst_n` is low, `gnt_o` is all zero. After reset, every round-robin pointer starts at index 0, so the first contested grant of an output goes to the lowest-numbered requesting input.
- R9: The round-robin pointers move only on normal grants. A pointer is set to one past the index of the winner. Held grants leave the pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Policy: 0 plain round-robin, 1 hold, 2 row-hold (3 acts as plain) |
| req_i | input | N_IN*N_OUT | Request matrix; bit i*N_OUT+o means input i wants output o |
| row_i | input | N_IN*ROW_W | Row tag per input; input i at bits [i*ROW_W +: ROW_W] |
| gnt_o | output | N_IN*N_OUT | Grant matrix, same bit layout as req_i |

## Verification
A held pair and a normal arbitration result can appear in the same cycle. One test sets up a hold on input 1 to output 0 and, in the next cycle, has input 1 and a competing input both request outputs 0 and 1. The expected result is that input 1 keeps output 0. Output 1 must go to the competing input, and input 1 must not also receive output 1. A second pair of cases puts a row change against a pointer that favours another input: the expected grant shows whether the hold or the round-robin pointer decided the output.

// File: rtl/rmhg_pkg.sv
package rmhg_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'd0,
        MODE_HOLD    = 2'd1,
        MODE_ROWHOLD = 2'd2
    } alloc_mode_e;

    function automatic logic mode_is_sticky(input logic [1:0] m);
        return (m == MODE_HOLD) || (m == MODE_ROWHOLD);
    endfunction

endpackage

// File: rtl/rmhg_rr_pick.sv
module rmhg_rr_pick #(
    parameter int N = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] ptr_i,
    output logic [N-1:0]  gnt_o,
    output logic [PW-1:0] idx_o
);

    logic found;

    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int p;
            p = (int'(ptr_i) + k) % N;
            if (!found && req_i[p]) begin
                found    = 1'b1;
                gnt_o[p] = 1'b1;
                idx_o    = PW'(p);
            end
        end
    end

endmodule

// File: rtl/rmhg_hold_table.sv
module rmhg_hold_table
    import rmhg_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int ROW_W = 8,
    localparam int IW   = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int NREQ = N_IN * N_OUT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode_i,
    input  logic [NREQ-1:0]        req_i,
    input  logic [N_IN*ROW_W-1:0]  row_i,
    input  logic [NREQ-1:0]        gnt_i,
    output logic [N_IN-1:0]        held_in_o,
    output logic [N_OUT-1:0]       held_out_o,
    output logic [NREQ-1:0]        hold_gnt_o
);

    typedef struct packed {
        logic [N_OUT-1:0]             vld;
        logic [N_OUT-1:0][IW-1:0]     src;
        logic [N_OUT-1:0][ROW_W-1:0]  row;
        logic [1:0]                   mode;
    } hold_t;

    hold_t st_d, st_q;
    logic  live;

    // Which recorded pairs are honoured this cycle
    always_comb begin
        held_in_o  = '0;
        held_out_o = '0;
        hold_gnt_o = '0;
        live = mode_is_sticky(mode_i) && (mode_i == st_q.mode);
        for (int o = 0; o < N_OUT; o++) begin
            int s;
            s = int'(st_q.src[o]);
            if (live && st_q.vld[o] && req_i[s*N_OUT + o] &&
                ((mode_i == MODE_HOLD) ||
                 (row_i[s*ROW_W +: ROW_W] == st_q.row[o]))) begin
                held_in_o[s]          = 1'b1;
                held_out_o[o]         = 1'b1;
                hold_gnt_o[s*N_OUT+o] = 1'b1;
            end
        end
    end

    // Record this cycle's winners for the next cycle
    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_i;
        for (int o = 0; o < N_OUT; o++) begin
            st_d.vld[o] = 1'b0;
            for (int i = 0; i < N_IN; i++) begin
                if (gnt_i[i*N_OUT + o]) begin
                    st_d.vld[o] = mode_is_sticky(mode_i);
                    st_d.src[o] = IW'(i);
                    st_d.row[o] = row_i[i*ROW_W +: ROW_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A mode change must never be followed by an honoured hold
    AST_NO_HOLD_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != $past(mode_i)) |-> (hold_gnt_o == '0))
        else $error("hold honoured right after mode change"); // R7

endmodule

// File: rtl/rmhg_switch_alloc.sv
module rmhg_switch_alloc
    import rmhg_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int ROW_W = 8,
    localparam int IW   = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int OW   = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int NREQ = N_IN * N_OUT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic [NREQ-1:0]       req_i,
    input  logic [N_IN*ROW_W-1:0] row_i,
    output logic [NREQ-1:0]       gnt_o
);

    typedef struct packed {
        logic [N_IN-1:0][OW-1:0]  in_ptr;
        logic [N_OUT-1:0][IW-1:0] out_ptr;
    } ptr_t;

    ptr_t st_d, st_q;

    logic [N_IN-1:0]             held_in;
    logic [N_OUT-1:0]            held_out;
    logic [NREQ-1:0]             hold_gnt;
    logic [NREQ-1:0]             norm_gnt;
    logic [N_IN-1:0][N_OUT-1:0]  s1_req, s1_gnt;
    logic [N_IN-1:0][OW-1:0]     s1_idx;
    logic [N_OUT-1:0][N_IN-1:0]  s2_req, s2_gnt;
    logic [N_OUT-1:0][IW-1:0]    s2_idx;

    rmhg_hold_table #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT),
        .ROW_W (ROW_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .req_i      (req_i),
        .row_i      (row_i),
        .gnt_i      (gnt_o),
        .held_in_o  (held_in),
        .held_out_o (held_out),
        .hold_gnt_o (hold_gnt)
    );

    // Stage 1: one output chosen per input, held ports excluded
    for (genvar i = 0; i < N_IN; i++) begin : g_in_stage
        assign s1_req[i] = held_in[i] ? '0 : (req_i[i*N_OUT +: N_OUT] & ~held_out);
        rmhg_rr_pick #(.N(N_OUT)) u_in_arb (
            .req_i (s1_req[i]),
            .ptr_i (st_q.in_ptr[i]),
            .gnt_o (s1_gnt[i]),
            .idx_o (s1_idx[i])
        );
    end

    // Stage 2: one input chosen per output among stage-1 winners
    for (genvar o = 0; o < N_OUT; o++) begin : g_out_stage
        for (genvar i = 0; i < N_IN; i++) begin : g_col
            assign s2_req[o][i]           = s1_gnt[i][o];
            assign norm_gnt[i*N_OUT + o]  = s2_gnt[o][i];
        end
        rmhg_rr_pick #(.N(N_IN)) u_out_arb (
            .req_i (s2_req[o]),
            .ptr_i (st_q.out_ptr[o]),
            .gnt_o (s2_gnt[o]),
            .idx_o (s2_idx[o])
        );
    end

    assign gnt_o = rst_n ? (norm_gnt | hold_gnt) : '0;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_IN; i++) begin
            if (|norm_gnt[i*N_OUT +: N_OUT])
                st_d.in_ptr[i] = OW'((int'(s1_idx[i]) + 1) % N_OUT);
        end
        for (int o = 0; o < N_OUT; o++) begin
            if (|s2_req[o])
                st_d.out_ptr[o] = IW'((int'(s2_idx[o]) + 1) % N_IN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GNT_WANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0)
        else $error("grant without request"); // R1

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk_col
        logic [N_IN-1:0] col;
        for (genvar i = 0; i < N_IN; i++) begin : g_bit
            assign col[i] = gnt_o[i*N_OUT + o];

            AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == MODE_HOLD && $past(mode_i) == MODE_HOLD &&
                 $past(gnt_o[i*N_OUT + o]) && req_i[i*N_OUT + o])
                |-> gnt_o[i*N_OUT + o])
                else $error("hold pair dropped"); // R3

            AST_ROW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == MODE_ROWHOLD && $past(mode_i) == MODE_ROWHOLD &&
                 $past(gnt_o[i*N_OUT + o]) && req_i[i*N_OUT + o] &&
                 row_i[i*ROW_W +: ROW_W] == $past(row_i[i*ROW_W +: ROW_W]))
                |-> gnt_o[i*N_OUT + o])
                else $error("same-row pair dropped"); // R4
        end
        AST_ONE_PER_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col))
            else $error("output granted twice"); // R1
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_chk_row
        AST_ONE_PER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_o[i*N_OUT +: N_OUT]))
            else $error("input granted twice"); // R1
    end

endmodule

// File: tb/test_rmhg_switch_alloc.sv
module test_rmhg_switch_alloc;

    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int ROW_W = 8;
    localparam int NREQ  = N_IN * N_OUT;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            mode = 2'd0;
    logic [NREQ-1:0]       req = '0;
    logic [N_IN*ROW_W-1:0] row = '0;
    logic [NREQ-1:0]       gnt;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    logic [NREQ-1:0] exp_q [$];
    string           tag_q [$];

    always #10 clk = ~clk;

    rmhg_switch_alloc #(.N_IN(N_IN), .N_OUT(N_OUT), .ROW_W(ROW_W)) i_rmhg_switch_alloc (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .req_i  (req),
        .row_i  (row),
        .gnt_o  (gnt)
    );

    task automatic check(input bit ok, input string tag, input logic [NREQ-1:0] act,
                         input logic [NREQ-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected grant
    task automatic step(input logic [1:0] m, input logic [NREQ-1:0] r,
                        input logic [N_IN*ROW_W-1:0] rw, input logic [NREQ-1:0] e,
                        input string tag);
        @(posedge clk);
        #2;
        mode = m;
        req  = r;
        row  = rw;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare mid-cycle, plus matching constraints every cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                bit ok;
                ok = ((gnt & ~req) == '0);
                for (int o = 0; o < N_OUT; o++) begin
                    int c;
                    c = 0;
                    for (int i = 0; i < N_IN; i++) c += int'(gnt[i*N_OUT + o]);
                    if (c > 1) ok = 1'b0;
                end
                for (int i = 0; i < N_IN; i++)
                    if ($countones(gnt[i*N_OUT +: N_OUT]) > 1) ok = 1'b0;
                check(ok, "R1 matching constraint", gnt, gnt & req);
                if (exp_q.size() > 0) begin
                    logic [NREQ-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(gnt === e, t, gnt, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        req = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(gnt == '0, "R8 no grant in reset", gnt, '0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        req   = '0;

        // Plain round-robin, everyone wants output 0
        step(2'd0, 16'h1111, 32'h0, 16'h0001, "R8 R2 first grant to input 0");
        step(2'd0, 16'h1111, 32'h0, 16'h0010, "R2 rotate to input 1");
        step(2'd0, 16'h1111, 32'h0, 16'h0100, "R2 rotate to input 2");
        step(2'd0, 16'h1111, 32'h0, 16'h1000, "R2 rotate to input 3");

        // Hold mode
        step(2'd1, 16'h1111, 32'h0403_0201, 16'h0001, "R7 normal grant after switch");
        step(2'd1, 16'h1111, 32'h0403_0201, 16'h0001, "R3 pair held");
        step(2'd1, 16'h1111, 32'h0403_02AA, 16'h0001, "R3 held despite row change");
        step(2'd1, 16'h1110, 32'h0403_02AA, 16'h0010, "R5 request dropped, normal pick");
        step(2'd1, 16'h2330, 32'h0403_02AA, 16'h0210, "R6 hold plus normal same cycle");

        // Row-hold mode
        step(2'd2, 16'h0044, 32'h0000_2010, 16'h0004, "R4 initial normal grant");
        step(2'd2, 16'h0044, 32'h0000_2010, 16'h0004, "R4 same row held");
        step(2'd2, 16'h0044, 32'h0000_2011, 16'h0040, "R4 row change releases");
        step(2'd2, 16'h0044, 32'h0000_2011, 16'h0040, "R4 R9 hold beats pointer");
        step(2'd2, 16'h0044, 32'h0000_2111, 16'h0004, "R4 second release");

        // Mode switch clears held state
        step(2'd1, 16'h0044, 32'h0000_2111, 16'h0040, "R7 R9 switch ignores old hold");
        step(2'd1, 16'h0044, 32'h0000_2111, 16'h0040, "R3 hold resumes");
        step(2'd1, 16'h0044, 32'h0000_9911, 16'h0040, "R3 row ignored in hold mode");

        // Back to plain: no sticking
        step(2'd0, 16'h0044, 32'h0000_9911, 16'h0004, "R2 plain after switch");
        step(2'd0, 16'h0044, 32'h0000_9911, 16'h0040, "R2 plain alternates");

        @(posedge clk);
        #2;
        req = '0;
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule